// File: doc/BRIEF.md
# Binary Arithmetic Bin Coding Engine

This block is the interval-update core of a context-adaptive binary arithmetic encoder. Each cycle it accepts one packet: a context-coded bin with its probability state and most-probable symbol, a terminate bin, or a group of up to four bypass bins. It keeps the coding interval width (the range) in a register. For every packet it reports the renormalization shift and the amount to add to the low register. Context-coded packets also give back the updated probability state and most-probable symbol, which go back to context storage.

The engine has two pipeline stages. The first stage splits the interval: from the probability state alone it builds the four candidate least-probable sub-ranges, one per range quadrant, and both candidate next states. The second stage holds the range register. It picks the candidate that matches the current range quadrant, updates the range and renormalizes it in the same cycle. The range loop therefore closes within one stage, and a packet can enter every cycle. The low register and bit packing sit downstream. The downstream stage forms `low_new = (low << out_shift) + out_low_add`.

Top module: `ace_bin_engine`

## Requirements
- R1: After reset, `out_valid` is low and `out_range` reads 510.
- R2: A packet accepted with `in_valid` high at one rising edge produces `out_valid` high after the second rising edge. Packets may arrive on every cycle.
- R3: For a context-coded bin, q is range bits [7:6]. The least-probable sub-range is ((9 + 2q) * (64 - state)) >> 2, and the most-probable sub-range is the range minus it.
- R4: A context-coded bin equal to the MPS takes the most-probable sub-range as the new range and contributes nothing to low.
- R5: A context-coded bin that differs from the MPS takes the least-probable sub-range as the new range and adds the most-probable sub-range to low before the shift.
- R6: The next state after an MPS is state + 1 for states below 62, and otherwise stays unchanged. The next state after an LPS is state - 1 - (state >> 2), and state 0 stays 0.
- R7: An LPS in state 0 inverts the MPS. In every other case the MPS is kept.
- R8: The shift equals the number of leading zeros of the new 9-bit range. `out_range` is the shifted range, which is always at least 256. `out_low_add` is the pre-shift addend shifted left by the same amount.
- R9: A bypass packet with count n shifts by n and adds range * (bits & (2^n - 1)), with the earliest bin in bit n-1. The range does not change.
- R10: A bypass count above 4 is treated as 4. A count of 0 gives shift 0 and addend 0.
- R11: A terminate bin of value 0 reduces the range by 2, then renormalizes it, and adds nothing to low.
- R12: A terminate bin of value 1 adds (range - 2) << 7 to low, reports shift 7 and leaves the range at 256.
- R13: Mode values are 0 for context-coded, 1 for bypass and 2 for terminate. Mode 3 gives shift 0 and addend 0 and leaves the range unchanged. Every packet that is not context-coded returns its input state and MPS unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Packet present |
| in_mode | input | 2 | Packet kind: 0 context, 1 bypass, 2 terminate, 3 none |
| in_bin | input | 1 | Bin value (context or terminate) |
| in_state | input | 6 | Context probability state |
| in_mps | input | 1 | Context most-probable symbol |
| in_byp_bits | input | 4 | Bypass bins, earliest in bit count-1 |
| in_byp_cnt | input | 3 | Number of bypass bins |
| out_valid | output | 1 | Result present |
| out_state | output | 6 | Updated probability state |
| out_mps | output | 1 | Updated most-probable symbol |
| out_shift | output | 3 | Renormalization shift for low |
| out_low_add | output | 16 | Addend applied to low after the shift |
| out_range | output | 9 | Range register after this packet |

## Verification
The bench first sends hand-picked context-coded bins. These include MPS and LPS hits in different range quadrants, an LPS in state 0 and an MPS at the state ceiling, which separate the quadrant selection, the two transition rules and the MPS flip. An LPS at the highest state forces the largest shift of 7 and tests the renormalization. Bypass groups with counts 0, 3 and above 4, terminate bins of both values and the unused mode then check the packet kinds that leave the range alone or handle it specially. A long back-to-back mixed stream produced by a shift register follows. It shows that the range carried from packet to packet stays correct when packets arrive every cycle.

// File: rtl/ace_pkg.sv
// Shared types and helpers for the bin coding engine.
package ace_pkg;

    typedef enum logic [1:0] {
        MODE_REG = 2'd0,
        MODE_BYP = 2'd1,
        MODE_TRM = 2'd2,
        MODE_NOP = 2'd3
    } ace_mode_e;

    // Counts the leading zeros of the lowest `width` bits of v.
    function automatic int lead_zeros(input logic [31:0] v, input int width);
        int   n;
        logic seen;
        n    = 0;
        seen = 1'b0;
        for (int i = 31; i >= 0; i--) begin
            if (i < width && !seen) begin
                if (v[i]) seen = 1'b1;
                else      n    = n + 1;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/ace_split_stage.sv
// Stage 1: interval split. From the probability state alone it builds one
// least-probable sub-range candidate per range quadrant and both next-state
// candidates, then registers them with the packet.
// Assumes the range is normalized (top bit set), so that quadrant q
// covers the range values 256+64q to 319+64q.
module ace_split_stage #(
    parameter int RANGE_W = 9,
    parameter int STATE_W = 6,
    parameter int BYP_W   = 4,
    parameter int CNT_W   = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [1:0]                     in_mode,
    input  logic                           in_bin,
    input  logic [STATE_W-1:0]             in_state,
    input  logic                           in_mps,
    input  logic [BYP_W-1:0]               in_byp_bits,
    input  logic [CNT_W-1:0]               in_byp_cnt,
    output logic                           s1_valid,
    output logic [1:0]                     s1_mode,
    output logic                           s1_bin,
    output logic [STATE_W-1:0]             s1_state,
    output logic                           s1_mps,
    output logic [BYP_W-1:0]               s1_bits,
    output logic [CNT_W-1:0]               s1_cnt,
    output logic [3:0][RANGE_W-1:0]        s1_cand,
    output logic [STATE_W-1:0]             s1_st_mps,
    output logic [STATE_W-1:0]             s1_st_lps
);
    localparam int STATE_LEVELS = 2 ** STATE_W;
    localparam int MPS_CAP      = STATE_LEVELS - 2;
    localparam int QUAD_STEP    = 2 ** (RANGE_W - 3);
    localparam int QBASE        = (2 ** (RANGE_W - 1) + QUAD_STEP / 2) / (QUAD_STEP / 2);

    logic [3:0][RANGE_W-1:0] cand_d;
    logic [STATE_W-1:0]      st_mps_d, st_lps_d;

    // One sub-range candidate per quadrant.
    for (genvar g = 0; g < 4; g++) begin : g_quad
        assign cand_d[g] = RANGE_W'(((QBASE + 2 * g) * (STATE_LEVELS - int'(in_state))) >> 2);
    end

    // Next-state candidates for both outcomes.
    always_comb begin
        st_mps_d = (int'(in_state) < MPS_CAP) ? in_state + STATE_W'(1) : in_state;
        st_lps_d = (in_state == '0) ? '0
                 : in_state - STATE_W'(1) - (in_state >> 2);
    end

    // Pipeline register between split and range update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_mode   <= '0;
            s1_bin    <= 1'b0;
            s1_state  <= '0;
            s1_mps    <= 1'b0;
            s1_bits   <= '0;
            s1_cnt    <= '0;
            s1_cand   <= '0;
            s1_st_mps <= '0;
            s1_st_lps <= '0;
        end else begin
            s1_valid  <= in_valid;
            s1_mode   <= in_mode;
            s1_bin    <= in_bin;
            s1_state  <= in_state;
            s1_mps    <= in_mps;
            s1_bits   <= in_byp_bits;
            s1_cnt    <= in_byp_cnt;
            s1_cand   <= cand_d;
            s1_st_mps <= st_mps_d;
            s1_st_lps <= st_lps_d;
        end
    end
endmodule

// File: rtl/ace_range_stage.sv
// Stage 2: range update. Holds the range register. It picks the candidate
// for the current quadrant, applies the packet kind, renormalizes in one
// step and registers the results.
// Assumes the range register stays normalized, which this stage ensures.
module ace_range_stage #(
    parameter int RANGE_W = 9,
    parameter int STATE_W = 6,
    parameter int BYP_W   = 4,
    parameter int CNT_W   = 3,
    parameter int SHIFT_W = 3,
    parameter int LOW_W   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    s1_valid,
    input  logic [1:0]              s1_mode,
    input  logic                    s1_bin,
    input  logic [STATE_W-1:0]      s1_state,
    input  logic                    s1_mps,
    input  logic [BYP_W-1:0]        s1_bits,
    input  logic [CNT_W-1:0]        s1_cnt,
    input  logic [3:0][RANGE_W-1:0] s1_cand,
    input  logic [STATE_W-1:0]      s1_st_mps,
    input  logic [STATE_W-1:0]      s1_st_lps,
    output logic                    out_valid,
    output logic [STATE_W-1:0]      out_state,
    output logic                    out_mps,
    output logic [SHIFT_W-1:0]      out_shift,
    output logic [LOW_W-1:0]        out_low_add,
    output logic [RANGE_W-1:0]      out_range
);
    import ace_pkg::*;

    localparam logic [RANGE_W-1:0] RANGE_INIT = RANGE_W'(2 ** RANGE_W - 2);
    localparam logic [RANGE_W-1:0] RANGE_HALF = RANGE_W'(2 ** (RANGE_W - 1));
    localparam int                 TERM_SH    = RANGE_W - 2;

    logic [RANGE_W-1:0] range_q, r_lps, r_mps, r_pre, r_trm, r_n;
    logic               is_lps;
    logic [CNT_W-1:0]   byp_n;
    logic [BYP_W-1:0]   byp_mask;
    logic [SHIFT_W-1:0] sh_n;
    logic [LOW_W-1:0]   add_n;
    logic [STATE_W-1:0] state_n;
    logic               mps_n;

    // Packet evaluation against the current range.
    always_comb begin
        r_lps  = s1_cand[range_q[RANGE_W-2 -: 2]];
        r_mps  = range_q - r_lps;
        r_trm  = range_q - RANGE_W'(2);
        is_lps = s1_bin != s1_mps;
        byp_n  = (s1_cnt > CNT_W'(BYP_W)) ? CNT_W'(BYP_W) : s1_cnt;
        for (int i = 0; i < BYP_W; i++) byp_mask[i] = CNT_W'(i) < byp_n;
        r_pre   = '0;
        r_n     = range_q;
        sh_n    = '0;
        add_n   = '0;
        state_n = s1_state;
        mps_n   = s1_mps;
        case (ace_mode_e'(s1_mode))
            MODE_REG: begin
                r_pre   = is_lps ? r_lps : r_mps;
                sh_n    = SHIFT_W'(lead_zeros(32'(r_pre), RANGE_W));
                r_n     = r_pre << sh_n;
                add_n   = is_lps ? (LOW_W'(r_mps) << sh_n) : '0;
                state_n = is_lps ? s1_st_lps : s1_st_mps;
                mps_n   = s1_mps ^ (is_lps && s1_state == '0);
            end
            MODE_BYP: begin
                sh_n  = SHIFT_W'(byp_n);
                add_n = LOW_W'(range_q) * LOW_W'(s1_bits & byp_mask);
            end
            MODE_TRM: begin
                if (s1_bin) begin
                    sh_n  = SHIFT_W'(TERM_SH);
                    add_n = LOW_W'(r_trm) << TERM_SH;
                    r_n   = RANGE_HALF;
                end else begin
                    sh_n  = SHIFT_W'(lead_zeros(32'(r_trm), RANGE_W));
                    r_n   = r_trm << sh_n;
                end
            end
            default: ;
        endcase
    end

    // Range register and the registered results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            range_q     <= RANGE_INIT;
            out_valid   <= 1'b0;
            out_state   <= '0;
            out_mps     <= 1'b0;
            out_shift   <= '0;
            out_low_add <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                range_q     <= r_n;
                out_state   <= state_n;
                out_mps     <= mps_n;
                out_shift   <= sh_n;
                out_low_add <= add_n;
            end
        end
    end

    assign out_range = range_q;
endmodule

// File: rtl/ace_bin_engine.sv
// Top level: two-stage arithmetic coding engine for context-coded, bypass
// and terminate bins. Packets may arrive on every cycle. Results appear
// two cycles later.
// Assumes the bypass bins are packed with the earliest bin in bit count-1.
module ace_bin_engine #(
    parameter int RANGE_W = 9,
    parameter int STATE_W = 6,
    parameter int BYP_W   = 4,
    parameter int CNT_W   = 3,
    parameter int SHIFT_W = 3,
    parameter int LOW_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         in_mode,
    input  logic               in_bin,
    input  logic [STATE_W-1:0] in_state,
    input  logic               in_mps,
    input  logic [BYP_W-1:0]   in_byp_bits,
    input  logic [CNT_W-1:0]   in_byp_cnt,
    output logic               out_valid,
    output logic [STATE_W-1:0] out_state,
    output logic               out_mps,
    output logic [SHIFT_W-1:0] out_shift,
    output logic [LOW_W-1:0]   out_low_add,
    output logic [RANGE_W-1:0] out_range
);
    logic                    s1_valid, s1_bin, s1_mps;
    logic [1:0]              s1_mode;
    logic [STATE_W-1:0]      s1_state, s1_st_mps, s1_st_lps;
    logic [BYP_W-1:0]        s1_bits;
    logic [CNT_W-1:0]        s1_cnt;
    logic [3:0][RANGE_W-1:0] s1_cand;

    ace_split_stage #(
        .RANGE_W(RANGE_W), .STATE_W(STATE_W), .BYP_W(BYP_W), .CNT_W(CNT_W)
    ) u_split (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_mode(in_mode), .in_bin(in_bin),
        .in_state(in_state), .in_mps(in_mps),
        .in_byp_bits(in_byp_bits), .in_byp_cnt(in_byp_cnt),
        .s1_valid(s1_valid), .s1_mode(s1_mode), .s1_bin(s1_bin),
        .s1_state(s1_state), .s1_mps(s1_mps), .s1_bits(s1_bits),
        .s1_cnt(s1_cnt), .s1_cand(s1_cand),
        .s1_st_mps(s1_st_mps), .s1_st_lps(s1_st_lps)
    );

    ace_range_stage #(
        .RANGE_W(RANGE_W), .STATE_W(STATE_W), .BYP_W(BYP_W), .CNT_W(CNT_W),
        .SHIFT_W(SHIFT_W), .LOW_W(LOW_W)
    ) u_range (
        .clk(clk), .rst_n(rst_n),
        .s1_valid(s1_valid), .s1_mode(s1_mode), .s1_bin(s1_bin),
        .s1_state(s1_state), .s1_mps(s1_mps), .s1_bits(s1_bits),
        .s1_cnt(s1_cnt), .s1_cand(s1_cand),
        .s1_st_mps(s1_st_mps), .s1_st_lps(s1_st_lps),
        .out_valid(out_valid), .out_state(out_state), .out_mps(out_mps),
        .out_shift(out_shift), .out_low_add(out_low_add), .out_range(out_range)
    );
endmodule

// File: rtl/ace_checker.sv
// Temporal checks on the engine's ports, attached to the top level by bind.
// Assumes in_valid stays low while reset is asserted.
module ace_checker #(
    parameter int RANGE_W = 9,
    parameter int STATE_W = 6,
    parameter int SHIFT_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [1:0]         in_mode,
    input logic               in_bin,
    input logic [STATE_W-1:0] in_state,
    input logic               in_mps,
    input logic               out_valid,
    input logic [STATE_W-1:0] out_state,
    input logic [SHIFT_W-1:0] out_shift,
    input logic [RANGE_W-1:0] out_range
);
    localparam int MPS_CAP = 2 ** STATE_W - 2;

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    a_r8_range_floor: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_range[RANGE_W-1]);

    a_r9_byp_range_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_valid, 2) && $past(in_mode, 2) == 2'd1)
        |-> out_range == $past(out_range));

    a_r12_term_one: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_valid, 2) && $past(in_mode, 2) == 2'd2 && $past(in_bin, 2))
        |-> (out_shift == SHIFT_W'(RANGE_W - 2) && out_range == RANGE_W'(2 ** (RANGE_W - 1))));

    a_r6_mps_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_valid, 2) && $past(in_mode, 2) == 2'd0
         && $past(in_bin, 2) == $past(in_mps, 2) && int'($past(in_state, 2)) < MPS_CAP)
        |-> out_state == $past(in_state, 2) + STATE_W'(1));

    a_r13_nop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_valid, 2) && $past(in_mode, 2) == 2'd3)
        |-> (out_shift == '0 && out_range == $past(out_range)));
endmodule

bind ace_bin_engine ace_checker #(
    .RANGE_W(RANGE_W), .STATE_W(STATE_W), .SHIFT_W(SHIFT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_bin(in_bin), .in_state(in_state), .in_mps(in_mps),
    .out_valid(out_valid), .out_state(out_state), .out_shift(out_shift),
    .out_range(out_range)
);

// File: tb/tb_ace_bin_engine.sv
// Scoreboard bench: the driver computes expected results from the
// requirements and queues them, and the monitor compares each result.
module tb_ace_bin_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_mode = '0;
    logic       in_bin = 1'b0;
    logic [5:0] in_state = '0;
    logic       in_mps = 1'b0;
    logic [3:0] in_byp_bits = '0;
    logic [2:0] in_byp_cnt = '0;
    logic        out_valid, out_mps;
    logic [5:0]  out_state;
    logic [2:0]  out_shift;
    logic [15:0] out_low_add;
    logic [8:0]  out_range;

    typedef struct {
        string tag;
        int    state;
        int    mps;
        int    shift;
        int    add;
        int    range;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails = 0;
    int   m_range = 510;

    ace_bin_engine dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_bin(in_bin), .in_state(in_state), .in_mps(in_mps),
        .in_byp_bits(in_byp_bits), .in_byp_cnt(in_byp_cnt),
        .out_valid(out_valid), .out_state(out_state), .out_mps(out_mps),
        .out_shift(out_shift), .out_low_add(out_low_add), .out_range(out_range)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input string what, input int got, input int want);
        checks++;
        if (got != want) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, want);
        end
    endtask

    // Model of one packet from the requirements; updates m_range.
    function automatic exp_t model(input string tag, input int mode, input int bin,
                                   input int st, input int mps, input int bits, input int cnt);
        exp_t e;
        int q, rl, rm, nr, pre, sh, n;
        e.tag = tag; e.state = st; e.mps = mps; e.shift = 0; e.add = 0;
        if (mode == 0) begin                    // R3 R4 R5 R6 R7 R8
            q  = (m_range / 64) % 4;
            rl = ((9 + 2 * q) * (64 - st)) / 4;
            rm = m_range - rl;
            nr = (bin != mps) ? rl : rm;
            pre = (bin != mps) ? rm : 0;
            sh = 0;
            while (nr < 256) begin nr = nr * 2; sh++; end
            e.shift = sh; e.add = pre << sh; m_range = nr;
            if (bin != mps) begin
                e.state = (st == 0) ? 0 : st - 1 - st / 4;
                if (st == 0) e.mps = 1 - mps;
            end else begin
                e.state = (st < 62) ? st + 1 : st;
            end
        end else if (mode == 1) begin           // R9 R10
            n = (cnt > 4) ? 4 : cnt;
            e.shift = n;
            e.add = m_range * (bits % (1 << n));
        end else if (mode == 2) begin           // R11 R12
            nr = m_range - 2;
            if (bin != 0) begin
                e.shift = 7; e.add = nr << 7; m_range = 256;
            end else begin
                sh = 0;
                while (nr < 256) begin nr = nr * 2; sh++; end
                e.shift = sh; m_range = nr;
            end
        end
        e.range = m_range;
        return e;
    endfunction

    // Driver: queue the expectation and present the packet for one cycle.
    task automatic send(input string tag, input int mode, input int bin, input int st,
                        input int mps, input int bits, input int cnt);
        exp_q.push_back(model(tag, mode, bin, st, mps, bits, cnt));
        @(negedge clk);
        in_valid = 1'b1; in_mode = 2'(mode); in_bin = 1'(bin);
        in_state = 6'(st); in_mps = 1'(mps); in_byp_bits = 4'(bits); in_byp_cnt = 3'(cnt);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: compare every result against the head of the queue.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R2", "unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, "state", int'(out_state), e.state);
                check(e.tag, "mps", int'(out_mps), e.mps);
                check(e.tag, "shift", int'(out_shift), e.shift);
                check(e.tag, "low_add", int'(out_low_add), e.add);
                check(e.tag, "range", int'(out_range), e.range);
            end
        end
    end

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out_valid after reset", int'(out_valid), 0);
        check("R1", "range after reset", int'(out_range), 510);

        send("R4_mps_hit", 0, 0, 10, 0, 0, 0);
        send("R5_lps_hit", 0, 0, 20, 1, 0, 0);
        send("R3_quadrant", 0, 1, 5, 1, 0, 0);
        send("R7_lps_state0", 0, 1, 0, 0, 0, 0);
        send("R6_mps_ceiling", 0, 1, 62, 1, 0, 0);
        send("R6_lps_step", 0, 0, 40, 1, 0, 0);
        send("R8_max_shift", 0, 1, 63, 0, 0, 0);
        send("R9_bypass3", 1, 0, 17, 1, 4'b1101, 3);
        send("R10_bypass_clamp", 1, 0, 3, 0, 4'b1111, 6);
        send("R10_bypass_zero", 1, 0, 9, 1, 4'b1010, 0);
        send("R11_term0", 2, 0, 12, 0, 0, 0);
        send("R12_term1", 2, 1, 33, 1, 0, 0);
        send("R13_nop", 3, 1, 44, 1, 4'b0111, 2);
        idle();
        repeat (3) @(negedge clk);

        // R2: long back-to-back mixed stream
        lf = 16'hACE1;
        for (int k = 0; k < 300; k++) begin
            int md;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            md = (lf[2:0] < 3'd5) ? 0 : ((lf[2:0] == 3'd5) ? 1 : ((lf[2:0] == 3'd6) ? 2 : 3));
            send("R2_stream", md, int'(lf[3]), int'(lf[9:4]), int'(lf[10]),
                 int'(lf[14:11]), int'(lf[15:13]));
        end
        idle();
        repeat (6) @(negedge clk);
        check("R2", "pending results", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule